// File: doc/BRIEF.md
# Memory-Immediate Logic Instruction Sequencer

This block runs a small family of 8-bit read-modify-write instructions for a processor core. Each instruction combines an immediate byte with a memory byte by AND, OR or XOR and writes the result back to the same location. A test form applies the AND but only updates the condition flags. The sequencer fetches its own instruction bytes over a byte-wide memory bus with a same-cycle read. It forms the effective address in one of two modes. A direct address uses the zero page. An indexed address adds an unsigned offset to the X register. Each opcode takes a fixed number of clock cycles.

Two single-byte instructions share the same front end. One exchanges the 16-bit D accumulator with X. The other puts the core into a sleep state that holds the bus quiet until a wake pulse arrives. The surrounding core hands over the program counter, X, D and the flags with a start pulse. It reads the updated registers back once done is signalled.

Top module: `memimm_seq`

## Requirements
- R1: Opcodes 0x71/0x72/0x75 (direct) and 0x61/0x62/0x65 (indexed) compute memory AND, OR and XOR with the immediate, in that order, and write the result back to the effective address.
- R2: Opcodes 0x7B (direct) and 0x6B (indexed) compute memory AND immediate, update only the flags and never assert mem_wr.
- R3: A memory instruction is read as three bytes: opcode at pc, immediate at pc+1, address byte at pc+2. The operand read follows them.
- R4: Direct effective address is 0x00 in the high byte and the address byte in the low byte. Indexed effective address is X plus the unsigned address byte, modulo 2^16.
- R5: Counting the clock edge that accepts start as edge 0, done is high during cycle 6 for direct AND/OR/XOR, 7 for indexed AND/OR/XOR, 4 for direct test and 5 for indexed test.
- R6: flags_out is {N,Z,V,C} in bits [3:0]. After any of the four logic operations, N is bit 7 of the result, Z is set when the result is zero, V is cleared and C is kept.
- R7: Opcode 0x18 swaps D and X. It completes with done in cycle 2, and the opcode is its only bus access.
- R8: Opcode 0x1A completes with done in cycle 4 and then holds sleeping high. While sleeping there is no bus access and start has no effect. A one-cycle wake pulse returns the block to idle, ready for start.
- R9: Any other opcode asserts illegal together with done in cycle 2. It writes no memory and leaves X, D and the flags unchanged.
- R10: busy is high in every cycle from cycle 1 through the done cycle and low on the next cycle. done lasts one cycle. A start pulse while busy has no effect.
- R11: After reset, busy, done, illegal, sleeping, mem_rd and mem_wr are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction at pc_in (taken only when idle) |
| pc_in | input | 16 | Address of the opcode byte |
| x_in | input | 16 | X register value loaded at start |
| d_in | input | 16 | D accumulator value loaded at start |
| flags_in | input | 4 | Flags {N,Z,V,C} loaded at start |
| wake | input | 1 | Leaves the sleep state |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| illegal | output | 1 | Unsupported opcode (with done) |
| sleeping | output | 1 | Sleep state |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Read strobe; data is expected the same cycle |
| mem_rdata | input | 8 | Read data |
| mem_wr | output | 1 | Write strobe, committed at the clock edge |
| mem_wdata | output | 8 | Write data |
| x_out | output | 16 | Current X register |
| d_out | output | 16 | Current D accumulator |
| flags_out | output | 4 | Current flags {N,Z,V,C} |

## Verification
The assertions take three things for granted about the inputs. mem_rdata must settle in the same cycle as a read strobe. start and wake must be synchronous single-cycle levels. The register and flag inputs only matter on the edge that accepts start. The bench memory answers reads combinationally from the address and commits writes on the clock edge. The bench changes every input half a cycle away from the active edge. Its start and wake pulses include deliberate ones during busy and sleep, to show they are dropped.

// File: rtl/memimm_pkg.sv
package memimm_pkg;

    typedef enum logic [1:0] {LOP_AND, LOP_OR, LOP_XOR, LOP_TST} lop_e;

    typedef enum logic [1:0] {K_MEM, K_XCHG, K_SLEEP, K_BAD} kind_e;

    typedef struct packed {
        kind_e kind;
        lop_e  lop;
        logic  indexed;
    } dec_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic [3:0] {
        S_IDLE, S_OP, S_DEC, S_ADR, S_IDX, S_RD, S_MOD, S_WR, S_SLW, S_SLEEP
    } st_e;

    localparam int SLP_CYCLES = 4;
    localparam logic [7:0] OPC_XCHG  = 8'h18;
    localparam logic [7:0] OPC_SLEEP = 8'h1A;

    function automatic flags_t logic_flags(input logic [7:0] r, input flags_t f);
        flags_t o;
        o.n = r[7];
        o.z = (r == 8'h00);
        o.v = 1'b0;
        o.c = f.c;
        return o;
    endfunction

endpackage

// File: rtl/memimm_decode.sv
module memimm_decode
    import memimm_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    logic mode_ok;
    always_comb begin
        dec.kind    = K_BAD;
        dec.lop     = LOP_AND;
        dec.indexed = (opcode[7:4] == 4'h6);
        mode_ok     = (opcode[7:4] == 4'h6) || (opcode[7:4] == 4'h7);
        if (opcode == OPC_XCHG) begin
            dec.kind = K_XCHG;
        end else if (opcode == OPC_SLEEP) begin
            dec.kind = K_SLEEP;
        end else if (mode_ok) begin
            case (opcode[3:0])
                4'h1: begin dec.kind = K_MEM; dec.lop = LOP_AND; end
                4'h2: begin dec.kind = K_MEM; dec.lop = LOP_OR;  end
                4'h5: begin dec.kind = K_MEM; dec.lop = LOP_XOR; end
                4'hB: begin dec.kind = K_MEM; dec.lop = LOP_TST; end
                default: dec.kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/memimm_agen.sv
module memimm_agen #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          indexed,
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] offset,
    output logic [AW-1:0] ea
);
    always_comb begin
        if (indexed) ea = base + AW'(offset);
        else         ea = {{(AW-DW){1'b0}}, offset};
    end
endmodule

// File: rtl/memimm_alu.sv
module memimm_alu
    import memimm_pkg::*;
#(
    parameter int DW = 8
) (
    input  lop_e          lop,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        case (lop)
            LOP_OR:  y = a | b;
            LOP_XOR: y = a ^ b;
            default: y = a & b;
        endcase
    end
endmodule

// File: rtl/memimm_seq.sv
module memimm_seq
    import memimm_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] x_in,
    input  logic [AW-1:0] d_in,
    input  logic [3:0]    flags_in,
    input  logic          wake,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic          sleeping,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] x_out,
    output logic [AW-1:0] d_out,
    output logic [3:0]    flags_out
);
    localparam int SCW = 2;
    localparam logic [SCW-1:0] SLW_LOAD = SCW'(SLP_CYCLES - 3);

    st_e           st;
    logic [AW-1:0] pc_r, x_r, d_r, ea_r;
    logic [DW-1:0] op_r, imm_r, off_r, data_r, res_r;
    flags_t        fl_r;
    logic [SCW-1:0] scnt;

    dec_t          dec;
    logic [AW-1:0] ea;
    logic [DW-1:0] agen_off, alu_a, alu_y;

    memimm_decode u_dec (
        .opcode(op_r),
        .dec   (dec)
    );

    assign agen_off = (st == S_ADR) ? mem_rdata : off_r;

    memimm_agen #(.DW(DW)) u_agen (
        .indexed(dec.indexed),
        .base   (x_r),
        .offset (agen_off),
        .ea     (ea)
    );

    assign alu_a = (st == S_RD) ? mem_rdata : data_r;

    memimm_alu #(.DW(DW)) u_alu (
        .lop(dec.lop),
        .a  (alu_a),
        .b  (imm_r),
        .y  (alu_y)
    );

    // Bus strobes and completion are decoded from the current step.
    always_comb begin
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        mem_addr = '0;
        done     = 1'b0;
        illegal  = 1'b0;
        case (st)
            S_OP: begin
                mem_rd   = 1'b1;
                mem_addr = pc_r;
            end
            S_DEC: begin
                case (dec.kind)
                    K_MEM: begin
                        mem_rd   = 1'b1;
                        mem_addr = pc_r + AW'(1);
                    end
                    K_XCHG:  done = 1'b1;
                    K_BAD: begin
                        done    = 1'b1;
                        illegal = 1'b1;
                    end
                    default: ;
                endcase
            end
            S_ADR: begin
                mem_rd   = 1'b1;
                mem_addr = pc_r + AW'(2);
            end
            S_RD: begin
                mem_rd   = 1'b1;
                mem_addr = ea_r;
                done     = (dec.lop == LOP_TST);
            end
            S_WR: begin
                mem_wr   = 1'b1;
                mem_addr = ea_r;
                done     = 1'b1;
            end
            S_SLW: done = (scnt == '0);
            default: ;
        endcase
    end

    assign busy      = (st != S_IDLE) && (st != S_SLEEP);
    assign sleeping  = (st == S_SLEEP);
    assign mem_wdata = res_r;
    assign x_out     = x_r;
    assign d_out     = d_r;
    assign flags_out = fl_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            pc_r   <= '0;
            x_r    <= '0;
            d_r    <= '0;
            ea_r   <= '0;
            op_r   <= '0;
            imm_r  <= '0;
            off_r  <= '0;
            data_r <= '0;
            res_r  <= '0;
            fl_r   <= '0;
            scnt   <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (start) begin
                        pc_r <= pc_in;
                        x_r  <= x_in;
                        d_r  <= d_in;
                        fl_r <= flags_t'(flags_in);
                        st   <= S_OP;
                    end
                end
                S_OP: begin
                    op_r <= mem_rdata;
                    st   <= S_DEC;
                end
                S_DEC: begin
                    case (dec.kind)
                        K_MEM: begin
                            imm_r <= mem_rdata;
                            st    <= S_ADR;
                        end
                        K_XCHG: begin
                            x_r <= d_r;
                            d_r <= x_r;
                            st  <= S_IDLE;
                        end
                        K_SLEEP: begin
                            scnt <= SLW_LOAD;
                            st   <= S_SLW;
                        end
                        default: st <= S_IDLE;
                    endcase
                end
                S_ADR: begin
                    off_r <= mem_rdata;
                    if (dec.indexed) begin
                        st <= S_IDX;
                    end else begin
                        ea_r <= ea;
                        st   <= S_RD;
                    end
                end
                S_IDX: begin
                    ea_r <= ea;
                    st   <= S_RD;
                end
                S_RD: begin
                    data_r <= mem_rdata;
                    if (dec.lop == LOP_TST) begin
                        fl_r <= logic_flags(alu_y, fl_r);
                        st   <= S_IDLE;
                    end else begin
                        st <= S_MOD;
                    end
                end
                S_MOD: begin
                    res_r <= alu_y;
                    st    <= S_WR;
                end
                S_WR: begin
                    fl_r <= logic_flags(res_r, fl_r);
                    st   <= S_IDLE;
                end
                S_SLW: begin
                    if (scnt == '0) st <= S_SLEEP;
                    else            scnt <= scnt - SCW'(1);
                end
                S_SLEEP: begin
                    if (wake) st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/memimm_seq_chk.sv
module memimm_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       wake,
    input logic       busy,
    input logic       done,
    input logic       illegal,
    input logic       sleeping,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic [3:0] flags_out
);
    a_r10_done_then_idle: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done));

    a_r10_start_taken: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !sleeping) |=> busy);

    a_r10_bus_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    a_r1_write_is_final: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (done && busy));

    a_r6_v_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(mem_wr) |-> !flags_out[1]);

    a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
        sleeping |-> (!mem_rd && !mem_wr && !busy));

    a_r8_wake_exit: assert property (@(posedge clk) disable iff (rst)
        (sleeping && wake) |=> (!sleeping && !busy));

    a_r9_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && !mem_wr));
endmodule

bind memimm_seq memimm_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .wake     (wake),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .sleeping (sleeping),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .flags_out(flags_out)
);

// File: tb/memimm_seq_test.sv
`timescale 1ns/1ps
module memimm_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pc_in = '0, x_in = '0, d_in = '0;
    logic [3:0]  flags_in = '0;
    logic        wake = 1'b0;
    logic        busy, done, illegal, sleeping, mem_rd, mem_wr;
    logic [15:0] mem_addr, x_out, d_out;
    logic [7:0]  mem_rdata, mem_wdata;
    logic [3:0]  flags_out;

    always #2.5 clk = ~clk;

    memimm_seq uut (
        .clk(clk), .rst(rst), .start(start), .pc_in(pc_in), .x_in(x_in),
        .d_in(d_in), .flags_in(flags_in), .wake(wake), .busy(busy),
        .done(done), .illegal(illegal), .sleeping(sleeping),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .x_out(x_out),
        .d_out(d_out), .flags_out(flags_out)
    );

    logic [7:0]  mem [1024];
    assign mem_rdata = mem[mem_addr[9:0]];

    logic        mon_clr = 1'b0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [15:0] rd_log [8];
    logic [15:0] last_wa = '0;

    always @(posedge clk) begin
        if (mon_clr) begin
            rd_cnt = 0;
            wr_cnt = 0;
        end else begin
            if (mem_wr) begin
                mem[mem_addr[9:0]] = mem_wdata;
                last_wa = mem_addr;
                wr_cnt++;
            end
            if (mem_rd) begin
                if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
                rd_cnt++;
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] pc, input logic [15:0] x, input logic [15:0] d,
                       input logic [3:0] f, input int poke_at,
                       output int cyc, output bit ill, output int bcyc);
        ill = 0;
        bcyc = 0;
        @(negedge clk);
        pc_in = pc; x_in = x; d_in = d; flags_in = f;
        start = 1'b1; mon_clr = 1'b1;
        @(negedge clk);
        start = 1'b0; mon_clr = 1'b0;
        cyc = 0;
        while (cyc < 40) begin
            cyc++;
            if (busy) bcyc++;
            if (illegal) ill = 1;
            if (cyc == poke_at) begin
                start = 1'b1;
                pc_in = 16'h03C0;
            end else begin
                start = 1'b0;
            end
            if (done) break;
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 illegal", illegal, 0);
        chk("R11 sleeping", sleeping, 0);
        chk("R11 bus strobes", {mem_rd, mem_wr}, 0);
    endtask

    task automatic t_mem(input logic [7:0] opc, input logic [15:0] pc, input logic [15:0] x,
                         input logic [7:0] imm, input logic [7:0] off, input logic [7:0] mval,
                         input logic [3:0] fin, input int poke_at);
        bit          idx, tst, ill;
        logic [15:0] ea;
        logic [7:0]  res;
        int          cyc, bcyc, ecyc;
        idx = (opc[7:4] == 4'h6);
        tst = (opc[3:0] == 4'hB);
        ea  = idx ? x + {8'h00, off} : {8'h00, off};
        case (opc[3:0])
            4'h2:    res = mval | imm;
            4'h5:    res = mval ^ imm;
            default: res = mval & imm;
        endcase
        ecyc = tst ? (idx ? 5 : 4) : (idx ? 7 : 6);
        mem[pc[9:0]] = opc;
        mem[pc[9:0] + 10'd1] = imm;
        mem[pc[9:0] + 10'd2] = off;
        mem[ea[9:0]] = mval;
        run(pc, x, 16'hA5C3, fin, poke_at, cyc, ill, bcyc);
        chk($sformatf("R5 cycles op %h", opc), cyc, ecyc);
        chk($sformatf("R10 busy cycles op %h", opc), bcyc, ecyc);
        chk($sformatf("R10 idle after op %h", opc), busy, 0);
        chk($sformatf("R3 opcode addr op %h", opc), rd_log[0], pc);
        chk($sformatf("R3 imm addr op %h", opc), rd_log[1], pc + 16'd1);
        chk($sformatf("R3 offset addr op %h", opc), rd_log[2], pc + 16'd2);
        chk($sformatf("R4 operand read addr op %h", opc), rd_log[3], ea);
        chk($sformatf("R6 flags op %h", opc), flags_out,
            {res[7], res == 8'h00, 1'b0, fin[0]});
        chk($sformatf("R9 no illegal op %h", opc), ill, 0);
        if (tst) begin
            chk($sformatf("R2 no write op %h", opc), wr_cnt, 0);
            chk($sformatf("R2 memory kept op %h", opc), mem[ea[9:0]], mval);
        end else begin
            chk($sformatf("R1 one write op %h", opc), wr_cnt, 1);
            chk($sformatf("R4 write addr op %h", opc), last_wa, ea);
            chk($sformatf("R1 result op %h", opc), mem[ea[9:0]], res);
        end
        chk($sformatf("R1 X kept op %h", opc), x_out, x);
    endtask

    task automatic t_xchg();
        int cyc, bcyc;
        bit ill;
        mem[10'h1B0] = 8'h18;
        run(16'h01B0, 16'h1357, 16'h9BDF, 4'b1010, 0, cyc, ill, bcyc);
        chk("R7 cycles", cyc, 2);
        chk("R7 X gets D", x_out, 16'h9BDF);
        chk("R7 D gets X", d_out, 16'h1357);
        chk("R7 single bus read", rd_cnt, 1);
        chk("R7 flags kept", flags_out, 4'b1010);
    endtask

    task automatic t_sleep();
        int cyc, bcyc;
        bit ill;
        mem[10'h1C0] = 8'h1A;
        mem[10'h3C0] = 8'h18;
        run(16'h01C0, 16'h0001, 16'h0002, 4'b0000, 0, cyc, ill, bcyc);
        chk("R8 cycles", cyc, 4);
        chk("R8 sleeping", sleeping, 1);
        repeat (4) @(negedge clk);
        pc_in = 16'h03C0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R8 start ignored in sleep", {sleeping, busy}, 2'b10);
        chk("R8 bus quiet in sleep", rd_cnt + wr_cnt, 1);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        chk("R8 woken", {sleeping, busy}, 2'b00);
        run(16'h03C0, 16'h4444, 16'h5555, 4'b0000, 0, cyc, ill, bcyc);
        chk("R8 start after wake", x_out, 16'h5555);
    endtask

    task automatic t_illegal(input logic [7:0] opc);
        int cyc, bcyc;
        bit ill;
        mem[10'h1E0] = opc;
        run(16'h01E0, 16'h2468, 16'h1357, 4'b0101, 0, cyc, ill, bcyc);
        chk($sformatf("R9 cycles op %h", opc), cyc, 2);
        chk($sformatf("R9 illegal seen op %h", opc), ill, 1);
        chk($sformatf("R9 no write op %h", opc), wr_cnt, 0);
        chk($sformatf("R9 regs kept op %h", opc), {x_out, d_out}, {16'h2468, 16'h1357});
        chk($sformatf("R9 flags kept op %h", opc), flags_out, 4'b0101);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mem(8'h71, 16'h0100, 16'h0000, 8'hF0, 8'h40, 8'h3C, 4'b0011, 0);
        t_mem(8'h72, 16'h0110, 16'h0000, 8'h80, 8'h44, 8'h01, 4'b0000, 0);
        t_mem(8'h75, 16'h0118, 16'h0000, 8'h5A, 8'h48, 8'h5A, 4'b1000, 0);
        t_mem(8'h61, 16'h0120, 16'h0200, 8'h0F, 8'h10, 8'hA7, 4'b0111, 0);
        t_mem(8'h62, 16'h0128, 16'h0220, 8'h00, 8'hFF, 8'h00, 4'b1001, 0);
        t_mem(8'h65, 16'h0140, 16'hFFF0, 8'hFF, 8'h20, 8'h0F, 4'b0000, 0);
        t_mem(8'h7B, 16'h0160, 16'h0000, 8'h81, 8'h50, 8'hF1, 4'b0010, 0);
        t_mem(8'h6B, 16'h0180, 16'h0300, 8'h0F, 8'h7F, 8'hF0, 4'b1001, 0);
        t_mem(8'h71, 16'h0190, 16'h0000, 8'h3F, 8'h58, 8'hFF, 4'b0000, 3);
        t_xchg();
        t_sleep();
        t_illegal(8'h55);
        t_illegal(8'h7C);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule